// File: doc/BRIEF.md
# Timed Power-Rail Sequence Runner

This block drives six board-level control pins through short, fixed power sequences: the enables of a 3.3 V and a 1.8 V rail kept alive in suspend, the enables of the matching 3.3 V and 1.8 V rails used only when running, an active-low processor reset and an active-low watchdog line to the power-management chip. A controller outside the block decides which transition to make. It picks one of four sequences with a 2-bit selector and pulses a start input. The runner then works through that sequence's entries in a small internal step table.

Each table entry names one pin, the level to drive it to, and a wait in milliseconds that follows the write. Waits are measured by counting pulses on a 1 ms tick input. An entry with no wait moves on to the next entry in the following clock cycle. After the last entry the runner raises a one-cycle completion pulse. The pins are registered and keep their levels between sequences, so each sequence only has to list the pins it changes.

Top module: `gpioSeqRunner`

## Requirements
- R1: While reset is asserted, all four rail enables are low, the processor reset is low, the watchdog line is high and the completion pulse is low.
- R2: Selector value 0 (bring-up to suspend) drives the suspend 3.3 V enable high and waits 2 ticks, then the suspend 1.8 V enable high and waits 2 ticks, then releases the processor reset high and waits 2 ticks.
- R3: Selector value 1 (suspend to running) drives the running 3.3 V enable high and then the running 1.8 V enable high, with no waits.
- R4: Selector value 2 (running to suspend) drives the running 3.3 V enable low and then the running 1.8 V enable low, with no waits.
- R5: Selector value 3 (shutdown) drives the processor reset low with no wait, then the suspend 1.8 V enable low and waits 2 ticks, then the suspend 3.3 V enable low and waits 2 ticks, then the watchdog low and waits 3 ticks, then the watchdog high.
- R6: A start pulse seen while idle makes the first entry's pin change on the next clock edge. Each following entry is written one cycle after the previous entry when that entry has no wait. Otherwise it is written one cycle after the edge that takes the last of that entry's tick pulses.
- R7: A start pulse that arrives while a sequence is in progress, including its completion cycle, has no effect on the pins or on the running sequence.
- R8: The completion pulse is high for exactly one cycle, in the cycle after the final entry finishes, and is otherwise low.
- R9: While idle the pins hold the levels the last sequence left them at.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| msTick | input | 1 | One-cycle pulse every millisecond |
| startPulse | input | 1 | Starts the selected sequence when idle |
| seqSel | input | 2 | Sequence select: 0 bring-up, 1 resume, 2 suspend, 3 shutdown |
| done | output | 1 | One-cycle completion pulse |
| en3v3S3 | output | 1 | Suspend 3.3 V rail enable |
| en1v8S3 | output | 1 | Suspend 1.8 V rail enable |
| en3v3S0 | output | 1 | Running 3.3 V rail enable |
| en1v8S0 | output | 1 | Running 1.8 V rail enable |
| apResetN | output | 1 | Processor reset, active low |
| pmicWdogN | output | 1 | Power-chip watchdog, active low |

## Verification
The four sequences run back to back in a power-up, resume, suspend, resume, shutdown order. Each one starts from the pin state the previous one left, so missing hold behaviour or a wrong entry level shows up as a pin mismatch. The two no-wait sequences give the exact cycle distance from start to completion. The timed sequences run against a tick that is not aligned to the clock, which separates a wait counted in ticks from one counted in cycles. A start pulse is injected in the middle of a timed sequence with the shutdown selector. It shows whether the runner restarts or ignores it, and idle stretches show whether the pins drift between sequences.

// File: rtl/seqRunnerPkg.sv
package seqRunnerPkg;

  parameter int SIG_ID_W   = 8;
  parameter int DELAY_W    = 8;
  parameter int NUM_PINS   = 6;
  parameter int STEP_IDX_W = 3;

  typedef enum logic [1:0] {
    SEQ_BRINGUP = 2'd0,
    SEQ_RESUME  = 2'd1,
    SEQ_SUSPEND = 2'd2,
    SEQ_SHUTDN  = 2'd3
  } seqKind_e;

  localparam logic [SIG_ID_W-1:0] PIN_SUS33  = SIG_ID_W'(0);
  localparam logic [SIG_ID_W-1:0] PIN_SUS18  = SIG_ID_W'(1);
  localparam logic [SIG_ID_W-1:0] PIN_RUN33  = SIG_ID_W'(2);
  localparam logic [SIG_ID_W-1:0] PIN_RUN18  = SIG_ID_W'(3);
  localparam logic [SIG_ID_W-1:0] PIN_CPURST = SIG_ID_W'(4);
  localparam logic [SIG_ID_W-1:0] PIN_WDOG   = SIG_ID_W'(5);

  localparam logic [NUM_PINS-1:0] PIN_RESET_VALUE = NUM_PINS'(1) << PIN_WDOG;

  typedef struct packed {
    logic [SIG_ID_W-1:0] sigId;
    logic                level;
    logic [DELAY_W-1:0]  delayMs;
    logic                last;
  } step_t;

  typedef struct packed {
    logic                writeEn;
    logic [SIG_ID_W-1:0] sigId;
    logic                level;
    logic                loadDelay;
    logic [DELAY_W-1:0]  delayMs;
    logic                countEn;
  } dpCtrl_t;

  function automatic step_t mkStep(logic [SIG_ID_W-1:0] id, logic lvl,
                                   int unsigned dly, logic isLast);
    step_t s;
    s.sigId   = id;
    s.level   = lvl;
    s.delayMs = DELAY_W'(dly);
    s.last    = isLast;
    return s;
  endfunction

endpackage

// File: rtl/seqStepRom.sv
module seqStepRom
  import seqRunnerPkg::*;
(
  input  seqKind_e              kind,
  input  logic [STEP_IDX_W-1:0] idx,
  output step_t                 step
);

  always_comb begin
    step = mkStep(PIN_WDOG, 1'b1, 0, 1'b1);
    unique case (kind)
      SEQ_BRINGUP: begin
        case (idx)
          STEP_IDX_W'(0): step = mkStep(PIN_SUS33, 1'b1, 2, 1'b0);
          STEP_IDX_W'(1): step = mkStep(PIN_SUS18, 1'b1, 2, 1'b0);
          STEP_IDX_W'(2): step = mkStep(PIN_CPURST, 1'b1, 2, 1'b1);
          default:        step = mkStep(PIN_CPURST, 1'b1, 0, 1'b1);
        endcase
      end
      SEQ_RESUME: begin
        case (idx)
          STEP_IDX_W'(0): step = mkStep(PIN_RUN33, 1'b1, 0, 1'b0);
          STEP_IDX_W'(1): step = mkStep(PIN_RUN18, 1'b1, 0, 1'b1);
          default:        step = mkStep(PIN_RUN18, 1'b1, 0, 1'b1);
        endcase
      end
      SEQ_SUSPEND: begin
        case (idx)
          STEP_IDX_W'(0): step = mkStep(PIN_RUN33, 1'b0, 0, 1'b0);
          STEP_IDX_W'(1): step = mkStep(PIN_RUN18, 1'b0, 0, 1'b1);
          default:        step = mkStep(PIN_RUN18, 1'b0, 0, 1'b1);
        endcase
      end
      SEQ_SHUTDN: begin
        case (idx)
          STEP_IDX_W'(0): step = mkStep(PIN_CPURST, 1'b0, 0, 1'b0);
          STEP_IDX_W'(1): step = mkStep(PIN_SUS18, 1'b0, 2, 1'b0);
          STEP_IDX_W'(2): step = mkStep(PIN_SUS33, 1'b0, 2, 1'b0);
          STEP_IDX_W'(3): step = mkStep(PIN_WDOG, 1'b0, 3, 1'b0);
          STEP_IDX_W'(4): step = mkStep(PIN_WDOG, 1'b1, 0, 1'b1);
          default:        step = mkStep(PIN_WDOG, 1'b1, 0, 1'b1);
        endcase
      end
      default: step = mkStep(PIN_WDOG, 1'b1, 0, 1'b1);
    endcase
  end

endmodule

// File: rtl/seqControl.sv
module seqControl
  import seqRunnerPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startPulse,
  input  logic [1:0]            seqSel,
  input  logic                  msTick,
  input  logic                  cntAtOne,
  input  step_t                 step,
  output seqKind_e              kind,
  output logic [STEP_IDX_W-1:0] idx,
  output dpCtrl_t               dpCtrl,
  output logic                  busy,
  output logic                  done
);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_APPLY = 2'd1,
    ST_WAIT  = 2'd2,
    ST_FIN   = 2'd3
  } state_e;

  state_e                state, stateNext;
  logic [STEP_IDX_W-1:0] idxNext;
  seqKind_e              kindNext;
  logic                  stepFinished;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= '0;
      kind  <= SEQ_BRINGUP;
    end else begin
      state <= stateNext;
      idx   <= idxNext;
      kind  <= kindNext;
    end
  end

  always_comb begin
    stepFinished = 1'b0;
    if (state == ST_APPLY) stepFinished = (step.delayMs == '0);
    if (state == ST_WAIT)  stepFinished = msTick && cntAtOne;
  end

  always_comb begin
    stateNext = state;
    idxNext   = idx;
    kindNext  = kind;
    unique case (state)
      ST_IDLE: begin
        if (startPulse) begin
          stateNext = ST_APPLY;
          idxNext   = '0;
          kindNext  = seqKind_e'(seqSel);
        end
      end
      ST_APPLY: begin
        if (!stepFinished) stateNext = ST_WAIT;
      end
      ST_WAIT: ;
      ST_FIN: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
    if (stepFinished) begin
      if (step.last) begin
        stateNext = ST_FIN;
      end else begin
        stateNext = ST_APPLY;
        idxNext   = idx + STEP_IDX_W'(1);
      end
    end
  end

  always_comb begin
    dpCtrl           = '0;
    dpCtrl.sigId     = step.sigId;
    dpCtrl.level     = step.level;
    dpCtrl.delayMs   = step.delayMs;
    dpCtrl.writeEn   = (state == ST_APPLY);
    dpCtrl.loadDelay = (state == ST_APPLY);
    dpCtrl.countEn   = (state == ST_WAIT) && msTick;
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);

endmodule

// File: rtl/seqDatapath.sv
module seqDatapath
  import seqRunnerPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  dpCtrl_t             dpCtrl,
  output logic [NUM_PINS-1:0] pinQ,
  output logic                cntAtOne
);

  logic [DELAY_W-1:0] delayCnt;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam logic [SIG_ID_W-1:0] MY_ID = SIG_ID_W'(p);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pinQ[p] <= PIN_RESET_VALUE[p];
      end else if (dpCtrl.writeEn && (dpCtrl.sigId == MY_ID)) begin
        pinQ[p] <= dpCtrl.level;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      delayCnt <= '0;
    end else if (dpCtrl.loadDelay) begin
      delayCnt <= dpCtrl.delayMs;
    end else if (dpCtrl.countEn && (delayCnt != '0)) begin
      delayCnt <= delayCnt - DELAY_W'(1);
    end
  end

  assign cntAtOne = (delayCnt == DELAY_W'(1));

endmodule

// File: rtl/gpioSeqRunner.sv
module gpioSeqRunner
  import seqRunnerPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  logic       startPulse,
  input  logic [1:0] seqSel,
  output logic       done,
  output logic       en3v3S3,
  output logic       en1v8S3,
  output logic       en3v3S0,
  output logic       en1v8S0,
  output logic       apResetN,
  output logic       pmicWdogN
);

  seqKind_e              kind;
  logic [STEP_IDX_W-1:0] idx;
  step_t                 step;
  dpCtrl_t               dpCtrl;
  logic                  cntAtOne;
  logic                  busy;
  logic [NUM_PINS-1:0]   pinQ;

  seqControl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .seqSel     (seqSel),
    .msTick     (msTick),
    .cntAtOne   (cntAtOne),
    .step       (step),
    .kind       (kind),
    .idx        (idx),
    .dpCtrl     (dpCtrl),
    .busy       (busy),
    .done       (done)
  );

  seqStepRom uRom (
    .kind (kind),
    .idx  (idx),
    .step (step)
  );

  seqDatapath uDp (
    .clk      (clk),
    .rstN     (rstN),
    .dpCtrl   (dpCtrl),
    .pinQ     (pinQ),
    .cntAtOne (cntAtOne)
  );

  assign en3v3S3   = pinQ[PIN_SUS33];
  assign en1v8S3   = pinQ[PIN_SUS18];
  assign en3v3S0   = pinQ[PIN_RUN33];
  assign en1v8S0   = pinQ[PIN_RUN18];
  assign apResetN  = pinQ[PIN_CPURST];
  assign pmicWdogN = pinQ[PIN_WDOG];

endmodule

// File: rtl/seqRunnerChecker.sv
module seqRunnerChecker (
  input logic       clk,
  input logic       rstN,
  input logic       startPulse,
  input logic       busy,
  input logic       done,
  input logic [5:0] pinVec
);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !startPulse) |=> $stable(pinVec));

  // R2
  reset_release_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pinVec[4]) |-> (pinVec[0] && pinVec[1]));

  // R3
  run_rise_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pinVec[3]) |-> pinVec[2]);

  // R4
  run_fall_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pinVec[2]) |-> pinVec[3]);

  // R5
  wdog_after_rails_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pinVec[5]) |-> (!pinVec[4] && !pinVec[1] && !pinVec[0]));

endmodule

bind gpioSeqRunner seqRunnerChecker uChk (
  .clk        (clk),
  .rstN       (rstN),
  .startPulse (startPulse),
  .busy       (busy),
  .done       (done),
  .pinVec     ({pmicWdogN, apResetN, en1v8S0, en3v3S0, en1v8S3, en3v3S3})
);

// File: tb/gpioSeqRunner_test.sv
module gpioSeqRunner_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       msTick = 1'b0;
  logic       startPulse = 1'b0;
  logic [1:0] seqSel = 2'd0;
  logic       done;
  logic       en3v3S3, en1v8S3, en3v3S0, en1v8S0, apResetN, pmicWdogN;
  wire  [5:0] pinVec = {pmicWdogN, apResetN, en1v8S0, en3v3S0, en1v8S3, en3v3S3};

  always #10 clk = ~clk;

  gpioSeqRunner uut (
    .clk(clk), .rstN(rstN), .msTick(msTick), .startPulse(startPulse),
    .seqSel(seqSel), .done(done), .en3v3S3(en3v3S3), .en1v8S3(en1v8S3),
    .en3v3S0(en3v3S0), .en1v8S0(en1v8S0), .apResetN(apResetN),
    .pmicWdogN(pmicWdogN)
  );

  int checks = 0;
  int errors = 0;
  bit comparing = 1'b0;
  bit finished = 1'b0;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Tick generator: one pulse every 7 cycles, not aligned to anything.
  int tickDiv = 0;
  int ticksSeen = 0;
  always @(negedge clk) begin
    tickDiv++;
    msTick = (tickDiv % 7 == 3);
  end

  // Behavioural reference: pending entries encoded as pin*1000 + level*100 + wait.
  int        q[$];
  int        mode = 0;
  int        waitLeft = 0;
  logic [5:0] expPins = 6'b100000;
  bit        expDone = 1'b0;
  string     runTag = "R9";

  function automatic string tagOf(int sel);
    case (sel)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic loadSeq(int sel);
    q.delete();
    case (sel)
      0: begin q.push_back(0102); q.push_back(1102); q.push_back(4102); end
      1: begin q.push_back(2100); q.push_back(3100); end
      2: begin q.push_back(2000); q.push_back(3000); end
      default: begin
        q.push_back(4000); q.push_back(1002); q.push_back(0002);
        q.push_back(5003); q.push_back(5100);
      end
    endcase
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mode = 0; expPins = 6'b100000; expDone = 1'b0; q.delete();
    end else begin
      case (mode)
        0: if (startPulse) begin
             loadSeq(int'(seqSel)); runTag = tagOf(int'(seqSel)); mode = 1;
           end
        1: begin
             int e;
             e = q[0];
             expPins[e / 1000] = ((e / 100) % 10) != 0;
             if (e % 100 == 0) begin
               void'(q.pop_front());
               mode = (q.size() == 0) ? 3 : 1;
             end else begin
               waitLeft = e % 100;
               mode = 2;
             end
           end
        2: if (msTick) begin
             waitLeft--;
             if (waitLeft == 0) begin
               void'(q.pop_front());
               mode = (q.size() == 0) ? 3 : 1;
             end
           end
        default: mode = 0;
      endcase
      expDone = (mode == 3);
    end
  end

  // Per-cycle comparison against the reference.
  always @(negedge clk) begin
    if (comparing && !finished) begin
      check(pinVec === expPins, !rstN ? "R1" : (mode == 0 ? "R9" : runTag),
            int'(pinVec), int'(expPins));
      check(done === expDone, !rstN ? "R1" : "R8", int'(done), int'(expDone));
    end
    if (msTick) ticksSeen++;
  end

  task automatic startSeq(int sel);
    @(negedge clk);
    seqSel = 2'(sel);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic waitDone(output int cyc);
    cyc = 0;
    while (done !== 1'b1 && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int cyc;
    int t0;
    repeat (3) @(negedge clk);
    comparing = 1'b1;
    // R1: reset levels
    check(pinVec === 6'b100000, "R1", int'(pinVec), 6'h20);
    check(done === 1'b0, "R1", int'(done), 0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R2 bring-up with a stray shutdown start in the middle (R7)
    t0 = ticksSeen;
    startSeq(0);
    repeat (10) @(negedge clk);
    seqSel = 2'd3; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    waitDone(cyc);
    check(done === 1'b1, "R8", int'(done), 1);
    check(ticksSeen - t0 >= 6, "R6", ticksSeen - t0, 6);
    @(negedge clk);
    check(pinVec === 6'b110011, "R7", int'(pinVec), 6'h33);
    check(done === 1'b0, "R8", int'(done), 0);

    // R9: idle hold
    repeat (20) @(negedge clk);
    check(pinVec === 6'b110011, "R9", int'(pinVec), 6'h33);

    // R3 resume: no waits, done after exactly two more edges (R6)
    startSeq(1);
    waitDone(cyc);
    check(cyc == 2, "R6", cyc, 2);
    @(negedge clk);
    check(pinVec === 6'b111111, "R3", int'(pinVec), 6'h3f);

    // R4 suspend
    startSeq(2);
    waitDone(cyc);
    check(cyc == 2, "R6", cyc, 2);
    @(negedge clk);
    check(pinVec === 6'b110011, "R4", int'(pinVec), 6'h33);

    // Resume again then shutdown
    startSeq(1);
    waitDone(cyc);
    repeat (5) @(negedge clk);
    t0 = ticksSeen;
    startSeq(3);
    waitDone(cyc);
    check(ticksSeen - t0 >= 7, "R5", ticksSeen - t0, 7);
    @(negedge clk);
    check(pinVec === 6'b101100, "R5", int'(pinVec), 6'h2c);

    // Finish powering down the run rails, then confirm idle hold.
    startSeq(2);
    waitDone(cyc);
    repeat (15) @(negedge clk);
    check(pinVec === 6'b100000, "R9", int'(pinVec), 6'h20);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule